// File: doc/BRIEF.md
# SD DAT Line Activity Tracker

This block keeps track of whether the data lines of an SD host controller are in use. It produces two status bits: line-active and data-inhibit. It also produces a one-cycle block-gap pulse, a one-cycle transfer-done pulse and a read-wait request.

It runs on the system clock and is fed by strobes from the command and data paths:

- a command end bit, with its direction and a flag for a busy-type response;
- a data block end bit, with a last-block flag;
- block gap reached;
- a resume (continue) write;
- a level that asks the transfer to halt at the next gap.

The card's DAT0 level is examined only on cycles where the SD clock enable is high. After each write block, the tracker waits for the card to release busy. A card that never pulls DAT0 low within a fixed number of SD clock ticks counts as not busy.

A read-transfer-active flag from the buffer logic is ORed into data-inhibit. When data-inhibit is low, the next command that uses the DAT lines may be issued.

Top module: `dat_line_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, datLineActive, dataInhibit, blkGapEvt, xferCmplt and readWaitReq are all 0.
- R2: cmdEndStb sets datLineActive from the next cycle. cmdIsWrite=1 selects the write direction and cmdIsWrite=0 selects the read direction.
- R3: During a read, blkEndStb with blkIsLast=1 clears datLineActive on the next cycle. No blkGapEvt or xferCmplt pulse is produced by this.
- R4: During a read with haltReq=1, gapReachedStb clears datLineActive on the next cycle. In that same cycle blkGapEvt is high for exactly one cycle. readWaitReq rises with it and stays high until the transfer resumes.
- R5: During a read, readWaitReq follows bufFull. If haltReq and bufFull are both 1, the read halts at the current gap on the next cycle, without waiting for gapReachedStb.
- R6: After a halt, contReqStb sets datLineActive again on the next cycle and drops readWaitReq. contReqStb has no effect when no halt is pending.
- R7: During a write, datLineActive stays 1 after the last block's end bit until busy is released. It then falls, and xferCmplt is high for exactly the one cycle in which datLineActive is first 0.
- R8: After a write block end bit, DAT0 is sampled on sdClkEn ticks. If 8 ticks pass with DAT0 high, busy counts as released. With a tick every cycle, datLineActive falls 9 cycles after the block end bit.
- R9: If DAT0 is seen low on one of the first 8 ticks, release waits for the first tick with DAT0 high. Cycles without sdClkEn advance neither the count nor the release.
- R10: During a write, release after a non-last block clears datLineActive only when haltReq=1, with an xferCmplt pulse. Without haltReq the line stays active.
- R11: A command end with cmdBusyResp=1 sets datLineActive. It then clears it through the same busy release as a last write block, with an xferCmplt pulse.
- R12: dataInhibit is 1 exactly when datLineActive or rdXferActive is 1.
- R13: A new write block end bit received while busy is still pending restarts the busy detection from zero ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sdClkEn | input | 1 | One-cycle tick per SD clock period |
| cmdEndStb | input | 1 | End bit of a data or busy command seen |
| cmdIsWrite | input | 1 | Direction of that command, 1 = write |
| cmdBusyResp | input | 1 | Command carries a busy-type response |
| blkEndStb | input | 1 | End bit of a data block |
| blkIsLast | input | 1 | That block is the last of the transfer |
| gapReachedStb | input | 1 | Read transfer reached a block gap |
| contReqStb | input | 1 | Software asked to resume a halted transfer |
| haltReq | input | 1 | Halt at the next block gap requested |
| bufFull | input | 1 | Read buffer cannot accept data |
| dat0 | input | 1 | Sampled DAT0 level |
| rdXferActive | input | 1 | Read transfer still active in buffer logic |
| datLineActive | output | 1 | DAT lines in use |
| dataInhibit | output | 1 | No DAT command may be issued |
| blkGapEvt | output | 1 | One-cycle block gap event |
| xferCmplt | output | 1 | One-cycle transfer complete event |
| readWaitReq | output | 1 | Drive read wait on DAT2 |

## Verification
The bench sweeps where and for how long the card holds DAT0 low after a write block, including lows that first appear on the eighth tick and cards that never pull low. A design that counts off by one, or that ignores a late low, releases the line on the wrong cycle.

It stalls the SD clock tick for many cycles to catch a counter that runs on the system clock. It re-issues a block end bit midway through busy to catch detection that does not restart.

The read halt is driven both through the gap strobe and through a full buffer. A wrong design would either fail to halt or emit a transfer-done pulse instead of a gap pulse.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  // Strobes and state the control hands to the datapath each cycle
  typedef struct packed {
    logic busyStart;
    logic lineActive;
    logic wrDir;
    logic halted;
  } ctrlStb_t;

  typedef enum logic [1:0] {
    BZ_IDLE  = 2'd0,
    BZ_WLOW  = 2'd1,
    BZ_WHIGH = 2'd2
  } busyPhase_t;
endpackage

// File: rtl/dlt_ctrl.sv
module dlt_ctrl
  import dlt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdEndStb,
  input  logic     cmdIsWrite,
  input  logic     cmdBusyResp,
  input  logic     blkEndStb,
  input  logic     blkIsLast,
  input  logic     gapReachedStb,
  input  logic     contReqStb,
  input  logic     haltReq,
  input  logic     bufFull,
  input  logic     busyDone,
  output ctrlStb_t stb
);
  logic active, wrDir, lastPend, halted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      wrDir    <= 1'b0;
      lastPend <= 1'b0;
      halted   <= 1'b0;
    end else if (cmdEndStb) begin
      active   <= 1'b1;
      wrDir    <= cmdIsWrite | cmdBusyResp;
      lastPend <= cmdBusyResp;
      halted   <= 1'b0;
    end else if (contReqStb && halted) begin
      active <= 1'b1;
      halted <= 1'b0;
    end else if (active && !wrDir) begin
      if (blkEndStb && blkIsLast) begin
        active <= 1'b0;
      end else if (haltReq && (gapReachedStb || bufFull)) begin
        active <= 1'b0;
        halted <= 1'b1;
      end
    end else if (active && wrDir) begin
      if (blkEndStb) begin
        lastPend <= blkIsLast;
      end else if (busyDone) begin
        if (lastPend) begin
          active <= 1'b0;
        end else if (haltReq) begin
          active <= 1'b0;
          halted <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.busyStart  = (cmdEndStb & cmdBusyResp) |
                     (!cmdEndStb & active & wrDir & blkEndStb);
    stb.lineActive = active;
    stb.wrDir      = wrDir;
    stb.halted     = halted;
  end
endmodule

// File: rtl/dlt_datapath.sv
module dlt_datapath
  import dlt_pkg::*;
#(
  parameter int BUSY_TICKS = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlStb_t stb,
  input  logic     sdClkEn,
  input  logic     dat0,
  input  logic     bufFull,
  output logic     busyDone,
  output logic     blkGapEvt,
  output logic     xferCmplt,
  output logic     readWaitReq
);
  localparam int CW = $clog2(BUSY_TICKS + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(BUSY_TICKS - 1);

  busyPhase_t phase;
  logic [CW-1:0] tickCnt;
  logic doneQ, prevActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= BZ_IDLE;
      tickCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (stb.busyStart) begin
        phase   <= BZ_WLOW;
        tickCnt <= '0;
      end else if (sdClkEn) begin
        unique case (phase)
          BZ_WLOW: begin
            if (!dat0) begin
              phase <= BZ_WHIGH;
            end else if (tickCnt == LAST_TICK) begin
              phase <= BZ_IDLE;
              doneQ <= 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
          BZ_WHIGH: begin
            if (dat0) begin
              phase <= BZ_IDLE;
              doneQ <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevActive <= 1'b0;
    else       prevActive <= stb.lineActive;
  end

  logic fallEdge;
  assign fallEdge    = prevActive & ~stb.lineActive;
  assign busyDone    = doneQ;
  assign blkGapEvt   = fallEdge & ~stb.wrDir & stb.halted;
  assign xferCmplt   = fallEdge & stb.wrDir;
  assign readWaitReq = ~stb.wrDir & ((stb.halted & ~stb.lineActive) |
                                     (stb.lineActive & bufFull));
endmodule

// File: rtl/dat_line_tracker.sv
module dat_line_tracker
  import dlt_pkg::*;
#(
  parameter int BUSY_TICKS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdClkEn,
  input  logic cmdEndStb,
  input  logic cmdIsWrite,
  input  logic cmdBusyResp,
  input  logic blkEndStb,
  input  logic blkIsLast,
  input  logic gapReachedStb,
  input  logic contReqStb,
  input  logic haltReq,
  input  logic bufFull,
  input  logic dat0,
  input  logic rdXferActive,
  output logic datLineActive,
  output logic dataInhibit,
  output logic blkGapEvt,
  output logic xferCmplt,
  output logic readWaitReq
);
  ctrlStb_t stb;
  logic busyDone;

  dlt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdEndStb(cmdEndStb), .cmdIsWrite(cmdIsWrite),
    .cmdBusyResp(cmdBusyResp), .blkEndStb(blkEndStb), .blkIsLast(blkIsLast),
    .gapReachedStb(gapReachedStb), .contReqStb(contReqStb), .haltReq(haltReq),
    .bufFull(bufFull), .busyDone(busyDone), .stb(stb)
  );

  dlt_datapath #(.BUSY_TICKS(BUSY_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdClkEn(sdClkEn), .dat0(dat0),
    .bufFull(bufFull), .busyDone(busyDone), .blkGapEvt(blkGapEvt),
    .xferCmplt(xferCmplt), .readWaitReq(readWaitReq)
  );

  assign datLineActive = stb.lineActive;
  assign dataInhibit   = stb.lineActive | rdXferActive;
endmodule

// File: rtl/dlt_checker.sv
module dlt_checker (
  input logic clk,
  input logic rstN,
  input logic cmdEndStb,
  input logic contReqStb,
  input logic rdXferActive,
  input logic datLineActive,
  input logic dataInhibit,
  input logic blkGapEvt,
  input logic xferCmplt,
  input logic readWaitReq
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> !datLineActive && !blkGapEvt && !xferCmplt);

  a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(datLineActive) |-> $past(cmdEndStb || contReqStb));

  a_r4_gap_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    blkGapEvt |=> !blkGapEvt);

  a_r4_gap_waits: assert property (@(posedge clk) disable iff (!rstN)
    blkGapEvt |-> readWaitReq && !datLineActive && $past(datLineActive));

  a_r7_tc_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    xferCmplt |=> !xferCmplt);

  a_r7_tc_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    xferCmplt |-> !datLineActive && $past(datLineActive));

  a_r7_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(xferCmplt && blkGapEvt));

  a_r12_inhibit_covers: assert property (@(posedge clk) disable iff (!rstN)
    (datLineActive || rdXferActive) |-> dataInhibit);

  a_r12_inhibit_free: assert property (@(posedge clk) disable iff (!rstN)
    (!datLineActive && !rdXferActive) |-> !dataInhibit);
endmodule

bind dat_line_tracker dlt_checker u_chk (
  .clk(clk), .rstN(rstN), .cmdEndStb(cmdEndStb), .contReqStb(contReqStb),
  .rdXferActive(rdXferActive), .datLineActive(datLineActive),
  .dataInhibit(dataInhibit), .blkGapEvt(blkGapEvt), .xferCmplt(xferCmplt),
  .readWaitReq(readWaitReq)
);

// File: tb/sim_dat_line_tracker.sv
`timescale 1ns/1ps
module sim_dat_line_tracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdClkEn = 1'b1, cmdEndStb = 1'b0, cmdIsWrite = 1'b0, cmdBusyResp = 1'b0;
  logic blkEndStb = 1'b0, blkIsLast = 1'b0, gapReachedStb = 1'b0;
  logic contReqStb = 1'b0, haltReq = 1'b0, bufFull = 1'b0, dat0 = 1'b1;
  logic rdXferActive = 1'b0;
  logic datLineActive, dataInhibit, blkGapEvt, xferCmplt, readWaitReq;

  int nChk = 0, nBad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dat_line_tracker u0 (.*);

  task automatic chk(string tag, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Cycle (edges after the block end bit) at which the line is first seen low.
  // lowAt: first tick edge with DAT0 low (>8 means the card never pulls low).
  function automatic int fallEdge(int lowAt, int lowLen);
    if (lowAt > 8) return 9;
    return lowAt + lowLen + 1;
  endfunction

  task automatic issueCmd(logic wr, logic bz);
    cmdEndStb = 1'b1; cmdIsWrite = wr; cmdBusyResp = bz;
    step();
    cmdEndStb = 1'b0; cmdBusyResp = 1'b0;
  endtask

  task automatic blockEnd(logic last);
    blkEndStb = 1'b1; blkIsLast = last;
    step();
    blkEndStb = 1'b0; blkIsLast = 1'b0;
  endtask

  // After the block-end edge: drive DAT0 per edge and check around the fall
  task automatic busyWatch(string tag, int lowAt, int lowLen);
    int f = fallEdge(lowAt, lowLen);
    for (int k = 1; k <= f + 1; k++) begin
      dat0 = (k >= lowAt && k < lowAt + lowLen) ? 1'b0 : 1'b1;
      step();
      if (k == f - 1) chk({tag, " still active"}, datLineActive, 1'b1);
      if (k == f) begin
        chk({tag, " released"}, datLineActive, 1'b0);
        chk({tag, " done pulse"}, xferCmplt, 1'b1);
      end
      if (k == f + 1) chk({tag, " pulse ends"}, xferCmplt, 1'b0);
    end
    dat0 = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2718));
    step(3);
    chk("R1 active in reset", datLineActive, 1'b0);
    chk("R1 inhibit in reset", dataInhibit, 1'b0);
    rstN = 1'b1;
    step();
    chk("R1 active after reset", datLineActive, 1'b0);
    chk("R1 wait after reset", readWaitReq, 1'b0);

    // R6: continue with nothing halted has no effect
    contReqStb = 1'b1; step(); contReqStb = 1'b0;
    chk("R6 stray continue", datLineActive, 1'b0);

    // R12 inhibit from the read flag alone
    rdXferActive = 1'b1; step();
    chk("R12 inhibit from read flag", dataInhibit, 1'b1);
    rdXferActive = 1'b0; step();
    chk("R12 inhibit clear", dataInhibit, 1'b0);

    // R2 + R3: read, last block
    issueCmd(1'b0, 1'b0);
    chk("R2 read sets active", datLineActive, 1'b1);
    chk("R12 inhibit follows line", dataInhibit, 1'b1);
    blockEnd(1'b0);
    chk("R3 non-last keeps active", datLineActive, 1'b1);
    blockEnd(1'b1);
    chk("R3 last clears", datLineActive, 1'b0);
    chk("R3 no gap pulse", blkGapEvt, 1'b0);
    chk("R3 no done pulse", xferCmplt, 1'b0);

    // R4 + R6: read halt at gap, then resume
    issueCmd(1'b0, 1'b0);
    haltReq = 1'b1; step(2);
    chk("R4 waits for gap", datLineActive, 1'b1);
    gapReachedStb = 1'b1; step(); gapReachedStb = 1'b0; haltReq = 1'b0;
    chk("R4 gap clears", datLineActive, 1'b0);
    chk("R4 gap pulse", blkGapEvt, 1'b1);
    chk("R4 read wait", readWaitReq, 1'b1);
    step();
    chk("R4 gap pulse ends", blkGapEvt, 1'b0);
    chk("R4 read wait held", readWaitReq, 1'b1);
    contReqStb = 1'b1; step(); contReqStb = 1'b0;
    chk("R6 resume sets active", datLineActive, 1'b1);
    chk("R6 resume drops wait", readWaitReq, 1'b0);

    // R5: full buffer halts at current gap
    bufFull = 1'b1; step();
    chk("R5 wait follows full", readWaitReq, 1'b1);
    chk("R5 full alone keeps active", datLineActive, 1'b1);
    haltReq = 1'b1; step(); haltReq = 1'b0; bufFull = 1'b0;
    chk("R5 halt at current gap", datLineActive, 1'b0);
    chk("R5 gap pulse", blkGapEvt, 1'b1);
    chk("R5 wait kept", readWaitReq, 1'b1);
    blockEnd(1'b1);
    chk("R5 still halted", datLineActive, 1'b0);
    contReqStb = 1'b1; step(); contReqStb = 1'b0;
    blockEnd(1'b1);

    // R7 + R8: write, card never pulls low
    issueCmd(1'b1, 1'b0);
    chk("R2 write sets active", datLineActive, 1'b1);
    blockEnd(1'b1);
    busyWatch("R8 timeout", 20, 0);

    // R9: low seen on the eighth tick
    issueCmd(1'b1, 1'b0); blockEnd(1'b1);
    busyWatch("R9 late low", 8, 4);

    // R9: ticks stalled do not advance detection
    issueCmd(1'b1, 1'b0); blockEnd(1'b1);
    sdClkEn = 1'b0; step(30);
    chk("R9 stalled tick holds", datLineActive, 1'b1);
    sdClkEn = 1'b1;
    busyWatch("R9 after stall", 20, 0);

    // R13: restart on a second block end mid-busy
    issueCmd(1'b1, 1'b0); blockEnd(1'b0);
    step(5);
    blockEnd(1'b1);
    busyWatch("R13 restart", 20, 0);

    // R10: non-last block without halt stays active; with halt clears
    issueCmd(1'b1, 1'b0); blockEnd(1'b0);
    step(15);
    chk("R10 no halt stays active", datLineActive, 1'b1);
    haltReq = 1'b1;
    blockEnd(1'b0);
    busyWatch("R10 halt", 3, 2);
    haltReq = 1'b0;
    chk("R10 no read wait on write", readWaitReq, 1'b0);
    contReqStb = 1'b1; step(); contReqStb = 1'b0;
    chk("R10 resume write", datLineActive, 1'b1);
    blockEnd(1'b1);
    busyWatch("R10 finish", 20, 0);

    // R11: busy-response command
    cmdEndStb = 1'b1; cmdIsWrite = 1'b0; cmdBusyResp = 1'b1;
    step();
    cmdEndStb = 1'b0; cmdBusyResp = 1'b0;
    chk("R11 busy cmd sets active", datLineActive, 1'b1);
    busyWatch("R11 busy cmd", 2, 5);

    // Random write busy profiles (R7, R8, R9)
    for (int i = 0; i < 40; i++) begin
      int lowAt = 1 + int'($urandom % 11);
      int lowLen = 1 + int'($urandom % 7);
      issueCmd(1'b1, 1'b0); blockEnd(1'b1);
      busyWatch("R9 random", lowAt, lowLen);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule